// File: doc/BRIEF.md
# Stopwatch counter with multiplexed display

This block is a minutes, seconds and hundredths stopwatch for a slow system clock, normally 10 kHz. A prescaler turns the clock into one hundredth-of-a-second step. A push-button input toggles between running and stopped each time it goes from released to pressed. The elapsed time is kept as six BCD digits, two each for minutes, seconds and hundredths.

The digits are shown on a six-digit seven-segment display that shares one set of segment lines. A scan counter lights one digit at a time and moves to the next digit on every clock. At 10 kHz each digit is refreshed at about 1.67 kHz. An active-low reset clears the time and stops the count without waiting for a clock edge.

Top module: `stopwatch_core`

## Requirements
- R1: While `rst_n` is low the block is cleared at once, without a clock edge. After reset the display reads 00:00:00 and the stopwatch is stopped until `run_key` is pressed.
- R2: Each 0-to-1 transition of `run_key` toggles the run state once, however long the key stays at 1. The toggle takes effect two clock edges after the key is first sampled high.
- R3: While the stopwatch is stopped, the time on the display does not change. Releasing `run_key` has no effect.
- R4: The prescaler counts only the clocks in the running state and keeps its phase across stops. After a total of N running clocks, the time shown equals floor(N / `TICK_DIV`) hundredths.
- R5: The hundredths run 00 to 99 and then carry into the seconds. The seconds run 00 to 59 and then carry into the minutes. All these carries take effect on the same clock edge.
- R6: The minutes run from 00 to `MIN_MOD`-1. The step after (`MIN_MOD`-1):59:99 gives 00:00:00. With the default value, 59:59:99 is followed by 00:00:00.
- R7: On every clock exactly one line of `dig_sel` is high, and the active line moves from bit k to bit k+1 (bit 5 wraps to bit 0). The bits show, in order 0 to 5: minutes tens, minutes ones, seconds tens, seconds ones, hundredths tens, hundredths ones.
- R8: `seg` is active high with bit 0 = A through bit 6 = G. Digits 0 to 9 light {0:0x3F, 1:0x06, 2:0x5B, 3:0x4F, 4:0x66, 5:0x6D, 6:0x7D, 7:0x07, 8:0x7F, 9:0x6F}. Codes 10 to 15 turn all segments off.
- R9: Every stored digit is valid BCD at all times. The tens of seconds never exceed 5, and the tens of minutes never exceed (`MIN_MOD`-1)/10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (10 kHz by default) |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_key | input | 1 | Start/stop push-button, 1 = pressed |
| dig_sel | output | 6 | One-hot digit select, bit 0 = leftmost digit |
| seg | output | 7 | Segment lines, bit 0 = A ... bit 6 = G, active high |

## Verification
The bench runs a small configuration (two clocks per hundredth, two minutes per wrap) and reads the time back only through the scanned display. For each readout it decodes the segment patterns into digits and checks the scan order.

Each run segment has its own length. The expected time comes from the total count of running clocks, so a prescaler that loses its phase across a stop, or that runs while stopped, shows up as an off-by-one hundredth. A long key hold catches a design that toggles on level instead of edge, because it would stop early. Runs that reach the top of the minutes field and step once more catch a cascade that wraps at the wrong digit or carries a cycle late. A reset applied in mid-run must give a frozen zero; a run flag that survives the reset would keep counting.

// File: rtl/sw_pkg.sv
`timescale 1ns/1ps
package sw_pkg;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] ones;
    } bcd2_t;

    // Active-high segments, bit 0 = A ... bit 6 = G; codes above 9 are blank.
    function automatic logic [6:0] bcd_to_seg(input logic [3:0] d);
        logic [6:0] s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sw_tick_gen.sv
`timescale 1ns/1ps
module sw_tick_gen #(
    parameter int TICK_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == LAST);
        if (run) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sw_key_toggle.sv
`timescale 1ns/1ps
module sw_key_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic key,
    output logic run,
    output logic press
);
    typedef struct packed {
        logic [1:0] hist;
        logic       run;
    } key_state_t;

    key_state_t st_d, st_q;

    always_comb begin
        press    = st_q.hist[0] & ~st_q.hist[1];
        st_d     = st_q;
        st_d.hist = {st_q.hist[0], key};
        st_d.run  = st_q.run ^ press;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run = st_q.run;
endmodule

// File: rtl/sw_bcd_field.sv
`timescale 1ns/1ps
module sw_bcd_field
    import sw_pkg::*;
#(
    parameter int MOD = 60
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inc,
    output bcd2_t value,
    output logic  carry
);
    localparam logic [3:0] TENS_TOP = 4'((MOD - 1) / 10);
    localparam logic [3:0] ONES_TOP = 4'((MOD - 1) % 10);

    bcd2_t st_d, st_q;
    logic  at_top;

    always_comb begin
        at_top = (st_q.tens == TENS_TOP) && (st_q.ones == ONES_TOP);
        carry  = inc && at_top;
        st_d   = st_q;
        if (inc) begin
            if (at_top) begin
                st_d = '0;
            end else if (st_q.ones == 4'd9) begin
                st_d.ones = 4'd0;
                st_d.tens = st_q.tens + 4'd1;
            end else begin
                st_d.ones = st_q.ones + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q;
endmodule

// File: rtl/sw_scan_mux.sv
`timescale 1ns/1ps
module sw_scan_mux
    import sw_pkg::*;
#(
    parameter int NUM_DIGITS = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_DIGITS-1:0][3:0] digits,
    output logic [NUM_DIGITS-1:0]      dig_sel,
    output logic [6:0]                 seg
);
    localparam int SW = $clog2(NUM_DIGITS);
    localparam logic [SW-1:0] LAST = SW'(NUM_DIGITS - 1);

    typedef struct packed {
        logic [SW-1:0] slot;
    } scan_state_t;

    scan_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.slot = (st_q.slot == LAST) ? '0 : st_q.slot + 1'b1;
        seg       = bcd_to_seg(digits[st_q.slot]);
    end

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
        assign dig_sel[g] = (st_q.slot == SW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/stopwatch_core.sv
`timescale 1ns/1ps
module stopwatch_core
    import sw_pkg::*;
#(
    parameter int TICK_DIV = 100,
    parameter int CS_MOD   = 100,
    parameter int SEC_MOD  = 60,
    parameter int MIN_MOD  = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_key,
    output logic [5:0] dig_sel,
    output logic [6:0] seg
);
    logic       run, press, tick;
    logic       cs_carry, sec_carry, min_carry;
    bcd2_t      cs_v, sec_v, min_v;
    logic [5:0][3:0] digits;

    sw_key_toggle u_key (
        .clk(clk), .rst_n(rst_n), .key(run_key), .run(run), .press(press)
    );

    sw_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    sw_bcd_field #(.MOD(CS_MOD)) u_cs (
        .clk(clk), .rst_n(rst_n), .inc(tick), .value(cs_v), .carry(cs_carry)
    );

    sw_bcd_field #(.MOD(SEC_MOD)) u_sec (
        .clk(clk), .rst_n(rst_n), .inc(cs_carry), .value(sec_v), .carry(sec_carry)
    );

    sw_bcd_field #(.MOD(MIN_MOD)) u_min (
        .clk(clk), .rst_n(rst_n), .inc(sec_carry), .value(min_v), .carry(min_carry)
    );

    // Slot 0 is the leftmost digit (minutes tens).
    assign digits = {cs_v.ones, cs_v.tens, sec_v.ones, sec_v.tens, min_v.ones, min_v.tens};

    sw_scan_mux #(.NUM_DIGITS(6)) u_scan (
        .clk(clk), .rst_n(rst_n), .digits(digits), .dig_sel(dig_sel), .seg(seg)
    );
endmodule

// File: rtl/sw_core_checker.sv
`timescale 1ns/1ps
module sw_core_checker #(
    parameter int CS_MOD  = 100,
    parameter int SEC_MOD = 60,
    parameter int MIN_MOD = 60
) (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic       press,
    input logic       tick,
    input logic [7:0] cs,
    input logic [7:0] sec,
    input logic [7:0] mins,
    input logic [5:0] dig_sel
);
    localparam logic [3:0] MIN_TENS_TOP = 4'((MIN_MOD - 1) / 10);
    localparam logic [7:0] CS_TOP  = {4'((CS_MOD - 1) / 10),  4'((CS_MOD - 1) % 10)};
    localparam logic [7:0] SEC_TOP = {4'((SEC_MOD - 1) / 10), 4'((SEC_MOD - 1) % 10)};
    localparam logic [7:0] MIN_TOP = {MIN_TENS_TOP,           4'((MIN_MOD - 1) % 10)};

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!run && cs == 8'h00 && sec == 8'h00 && mins == 8'h00));

    a_r2_press_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> (run != $past(run)));

    a_r3_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable({mins, sec, cs}));

    a_r4_tick_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    a_r6_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cs == CS_TOP && sec == SEC_TOP && mins == MIN_TOP)
        |=> (cs == 8'h00 && sec == 8'h00 && mins == 8'h00));

    a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(dig_sel));

    a_r7_scan_rotates: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dig_sel[0]) |=> dig_sel[1]);

    a_r9_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cs[3:0] <= 4'd9 && cs[7:4] <= 4'd9 && sec[3:0] <= 4'd9 && sec[7:4] <= 4'd5
         && mins[3:0] <= 4'd9 && mins[7:4] <= MIN_TENS_TOP));
endmodule

bind stopwatch_core sw_core_checker #(
    .CS_MOD(CS_MOD), .SEC_MOD(SEC_MOD), .MIN_MOD(MIN_MOD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .press(press), .tick(tick),
    .cs(cs_v), .sec(sec_v), .mins(min_v), .dig_sel(dig_sel)
);

// File: tb/stopwatch_core_tb.sv
`timescale 1ns/1ps
module stopwatch_core_tb;
    localparam int DIV = 2;
    localparam int MM  = 2;
    localparam int PERIOD_TICKS = MM * 6000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_key = 1'b0;
    logic [5:0] dig_sel;
    logic [6:0] seg;

    int checks = 0;
    int errors = 0;
    int run_cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stopwatch_core #(.TICK_DIV(DIV), .MIN_MOD(MM)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_key(run_key), .dig_sel(dig_sel), .seg(seg)
    );

    function automatic int seg_digit(input logic [6:0] s);
        case (s)
            7'h3F: return 0;
            7'h06: return 1;
            7'h5B: return 2;
            7'h4F: return 3;
            7'h66: return 4;
            7'h6D: return 5;
            7'h7D: return 6;
            7'h07: return 7;
            7'h7F: return 8;
            7'h6F: return 9;
            default: return 50;
        endcase
    endfunction

    function automatic int expect_time(input int ticks);
        int t = ticks % PERIOD_TICKS;
        return (t / 6000) * 10000 + ((t / 100) % 60) * 100 + (t % 100);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R7/R8: read the six digits off the scanned display.
    task automatic read_time(output int t);
        int dig[6];
        int prev = -1;
        int bad_order = 0;
        int bad_sel = 0;
        for (int d = 0; d < 6; d++) dig[d] = 50;
        for (int k = 0; k < 6; k++) begin
            int idx = -1;
            @(negedge clk);
            if ($countones(dig_sel) != 1) bad_sel++;
            for (int b = 0; b < 6; b++) if (dig_sel[b]) idx = b;
            if (idx >= 0) dig[idx] = seg_digit(seg);
            if (k > 0 && idx != (prev + 1) % 6) bad_order++;
            prev = idx;
        end
        check("R7 one select line", bad_sel, 0);
        check("R7 scan order", bad_order, 0);
        t = ((dig[0] * 10 + dig[1]) * 100 + dig[2] * 10 + dig[3]) * 100 + dig[4] * 10 + dig[5];
    endtask

    task automatic press(input int hold);
        @(negedge clk);
        run_key = 1'b1;
        repeat (hold) @(negedge clk);
        run_key = 1'b0;
    endtask

    // Start, run for hold+gap+1 clocks, stop, then compare the display.
    task automatic run_segment(input string tag, input int hold, input int gap);
        int t;
        press(hold);
        repeat (gap) @(negedge clk);
        press(3);
        run_cyc += hold + gap + 1;
        repeat (4) @(negedge clk);
        read_time(t);
        check(tag, t, expect_time(run_cyc / DIV));
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int t;
        int prev_t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state; R8 zero pattern on every digit
        read_time(t);
        check("R1 R8 display after reset", t, 0);

        // R4 R5 first run: carry from hundredths into seconds
        run_segment("R4 R5 first run", 3, 200);

        // R3 stopped display frozen, key release ignored
        read_time(prev_t);
        repeat (500) @(negedge clk);
        read_time(t);
        check("R3 frozen while stopped", t, prev_t);

        // R2 long hold toggles only once
        run_segment("R2 long hold single toggle", 60, 100);

        // R4 R8 sweep of run lengths, odd lengths test kept prescaler phase
        for (int k = 0; k < 10; k++) begin
            run_segment("R4 R8 sweep", 3, 97 * k + 13);
        end

        // R5 R6 approach the top of the minutes field, then wrap
        run_segment("R5 near top", 3, (PERIOD_TICKS - 2) * DIV - run_cyc - 4);
        run_segment("R6 wrap to zero", 3, 0);
        run_segment("R6 count after wrap", 3, 250);

        // R1 asynchronous reset in mid-run clears time and run flag
        press(3);
        repeat (50) @(negedge clk);
        #2 rst_n = 1'b0;
        #20 rst_n = 1'b1;
        run_cyc = 0;
        repeat (3) @(negedge clk);
        read_time(t);
        check("R1 reset mid-run clears", t, 0);
        repeat (300) @(negedge clk);
        read_time(t);
        check("R1 stopped after reset", t, 0);

        // R2 R4 restart after reset
        run_segment("R2 R4 restart", 3, 37);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule